// File: doc/BRIEF.md
# Spare Row and Column Repair Steering

This block sits between a memory's address and data pins and its cell array, and lets a small set of spare rows and one spare column stand in for rows and a column that are defective. Repair settings take the place of blown fuses. They are written through a configuration port while the memory is idle, and they stay fixed while the memory is used.

Every spare row holds a row address and a valid flag, and has its own equality comparator against the incoming row address. When a valid spare matches, that spare's word line fires and the normal row decoder is held off. For the data path, a thermometer-coded column setting moves each data bit at and above a defective position one physical column up. The defective column is then skipped and the extra column at the top is used in its place.

The cell array inside is a plain behavioural model. Parameters let it fake a set of stuck rows and one stuck column, so that the repair can be shown to work.

Top module: `redundant_mem`

## Requirements
- R1: After reset every spare is invalid and the column setting is zero. Addresses then decode to normal rows, and data bit i is stored in physical column i. The read data register resets to zero.
- R2: Spare k fires its word line (spareWl bit k) for an access exactly when it has been loaded with the valid flag set and its stored address equals memAddr. A spare loaded with the valid flag clear never fires.
- R3: Whenever any spare word line fires, every normal word line stays low, so no normal row is touched on that access.
- R4: With memEn high and no spare firing, exactly one normal word line is high, at index memAddr. With memEn low, no word line is high.
- R5: When several valid spares hold the same address, only the lowest-numbered one fires.
- R6: cfgColFuse is thermometer coded. Bit i set means data bits i and above are stored in physical column i+1. When the value is zero, column DATA_W (the spare) is unused. A column with a defect is bypassed by setting bits from its index up to the top bit.
- R7: A write (memEn=1, memWe=1) stores memWData at the clock edge. A read (memEn=1, memWe=0) presents the data on memRData after that edge. memRData holds its value in any cycle without a read.
- R8: With the stuck rows mapped to spares and the stuck column bypassed, every address reads back the data last written to it.
- R9: Writes that go to a spare row leave the normal row at the same address unchanged. Once the spare is invalidated, the old contents reappear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRowWe | input | 1 | Load one spare row's repair entry |
| cfgSpareIdx | input | SPARE_IDX_W | Which spare row to load |
| cfgRowAddr | input | ROW_AW | Row address that the spare replaces |
| cfgRowValid | input | 1 | Valid flag for the spare entry |
| cfgColWe | input | 1 | Load the column setting |
| cfgColFuse | input | DATA_W | Thermometer-coded column shift setting |
| memEn | input | 1 | Access request |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | ROW_AW | Row address |
| memWData | input | DATA_W | Write data |
| memRData | output | DATA_W | Registered read data |
| normWl | output | ROWS | Normal word lines for the current access |
| spareWl | output | NUM_SPARE | Spare word lines for the current access |

## Verification
Some properties can be checked on every clock cycle, and the assertions cover these:
- Normal and spare word lines never fire together.
- At most one spare fires at a time.
- The normal decode is one-hot at the requested address, and all word lines are quiet when there is no access.
- Read data holds its value between reads.

Other behaviour only shows up through the bench's scenarios:
- Stuck rows and a stuck column read back correctly once they are repaired.
- The lowest-numbered spare wins when spares hold the same address.
- The shifted data lands in the right physical columns.
- Normal rows keep their contents while they are shadowed by a spare.

// File: rtl/rmem_pkg.sv
package rmem_pkg;

  // Strobes from the repair control to the array datapath
  typedef struct packed {
    logic wrEn;      // store into the selected row this cycle
    logic rdEn;      // capture the selected row into the read register
    logic useSpare;  // selected row is a spare, not a normal row
  } rmemStrobe_t;

endpackage

// File: rtl/rmem_ctrl.sv
module rmem_ctrl
  import rmem_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int NUM_SPARE = 2,
  parameter int DATA_W = 8,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int SPARE_IDX_W = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgRowWe,
  input  logic [SPARE_IDX_W-1:0] cfgSpareIdx,
  input  logic [ROW_AW-1:0]      cfgRowAddr,
  input  logic                   cfgRowValid,
  input  logic                   cfgColWe,
  input  logic [DATA_W-1:0]      cfgColFuse,
  input  logic                   memEn,
  input  logic                   memWe,
  input  logic [ROW_AW-1:0]      memAddr,
  output rmemStrobe_t            strobe,
  output logic [DATA_W-1:0]      colShift,
  output logic [ROWS-1:0]        normWl,
  output logic [NUM_SPARE-1:0]   spareWl
);

  logic [ROW_AW-1:0]    repAddr [NUM_SPARE];
  logic [NUM_SPARE-1:0] repValid;
  logic [NUM_SPARE-1:0] spareMatch;
  logic                 anyHit;

  // Repair entries, one register set and comparator per spare row
  for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        repAddr[k]  <= '0;
        repValid[k] <= 1'b0;
      end else if (cfgRowWe && (cfgSpareIdx == SPARE_IDX_W'(k))) begin
        repAddr[k]  <= cfgRowAddr;
        repValid[k] <= cfgRowValid;
      end
    end
    assign spareMatch[k] = memEn && repValid[k] && (repAddr[k] == memAddr);
  end

  // Column shift setting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) colShift <= '0;
    else if (cfgColWe) colShift <= cfgColFuse;
  end

  // Lowest-numbered matching spare takes the access
  always_comb begin
    logic found;
    found   = 1'b0;
    spareWl = '0;
    for (int k = 0; k < NUM_SPARE; k++) begin
      if (spareMatch[k] && !found) begin
        spareWl[k] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign anyHit = |spareMatch;

  // Normal decoder, suppressed by any spare hit
  always_comb begin
    normWl = '0;
    if (memEn && !anyHit) normWl = ROWS'(1) << memAddr;
  end

  always_comb begin
    strobe.wrEn     = memEn && memWe;
    strobe.rdEn     = memEn && !memWe;
    strobe.useSpare = anyHit;
  end

endmodule

// File: rtl/rmem_dpath.sv
module rmem_dpath
  import rmem_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int NUM_SPARE = 2,
  parameter int DATA_W = 8,
  parameter logic [ROWS-1:0] BAD_ROW_MASK = '0,
  parameter int BAD_COL = -1,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int PHYS_W = DATA_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rmemStrobe_t          strobe,
  input  logic [DATA_W-1:0]    colShift,
  input  logic [NUM_SPARE-1:0] spareWl,
  input  logic [ROW_AW-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memWData,
  output logic [DATA_W-1:0]    memRData
);

  logic [PHYS_W-1:0] normArr  [ROWS];
  logic [PHYS_W-1:0] spareArr [NUM_SPARE];
  logic [PHYS_W-1:0] physWr;
  logic [PHYS_W-1:0] physRaw;
  logic [PHYS_W-1:0] physRd;
  logic [DATA_W-1:0] rdSteered;

  // Write steering: physical column j takes bit j, or bit j-1 when shifted
  for (genvar j = 0; j < PHYS_W; j++) begin : g_wcol
    if (j == 0) begin : g_first
      assign physWr[j] = colShift[0] ? 1'b0 : memWData[0];
    end else if (j == DATA_W) begin : g_last
      assign physWr[j] = colShift[j-1] ? memWData[j-1] : 1'b0;
    end else begin : g_mid
      assign physWr[j] = colShift[j]   ? memWData[j-1] :
                         colShift[j-1] ? memWData[j-1] : memWData[j];
    end
  end

  // Behavioural cell array
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      if (strobe.useSpare) begin
        for (int k = 0; k < NUM_SPARE; k++)
          if (spareWl[k]) spareArr[k] <= physWr;
      end else begin
        normArr[memAddr] <= physWr;
      end
    end
  end

  always_comb begin
    physRaw = '0;
    if (strobe.useSpare) begin
      for (int k = 0; k < NUM_SPARE; k++)
        if (spareWl[k]) physRaw = spareArr[k];
    end else begin
      physRaw = normArr[memAddr];
    end
  end

  // Defect model: stuck rows read zero, stuck column reads one
  always_comb begin
    physRd = physRaw;
    if (!strobe.useSpare && BAD_ROW_MASK[memAddr]) physRd = '0;
    for (int j = 0; j < PHYS_W; j++)
      if (j == BAD_COL) physRd[j] = 1'b1;
  end

  // Read steering: data bit i comes from column i or i+1
  for (genvar i = 0; i < DATA_W; i++) begin : g_rcol
    assign rdSteered[i] = colShift[i] ? physRd[i+1] : physRd[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) memRData <= '0;
    else if (strobe.rdEn) memRData <= rdSteered;
  end

endmodule

// File: rtl/redundant_mem.sv
module redundant_mem
  import rmem_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int NUM_SPARE = 2,
  parameter int DATA_W = 8,
  parameter logic [ROWS-1:0] BAD_ROW_MASK = '0,
  parameter int BAD_COL = -1,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int SPARE_IDX_W = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgRowWe,
  input  logic [SPARE_IDX_W-1:0] cfgSpareIdx,
  input  logic [ROW_AW-1:0]      cfgRowAddr,
  input  logic                   cfgRowValid,
  input  logic                   cfgColWe,
  input  logic [DATA_W-1:0]      cfgColFuse,
  input  logic                   memEn,
  input  logic                   memWe,
  input  logic [ROW_AW-1:0]      memAddr,
  input  logic [DATA_W-1:0]      memWData,
  output logic [DATA_W-1:0]      memRData,
  output logic [ROWS-1:0]        normWl,
  output logic [NUM_SPARE-1:0]   spareWl
);

  rmemStrobe_t       strobe;
  logic [DATA_W-1:0] colShift;

  rmem_ctrl #(.ROWS(ROWS), .NUM_SPARE(NUM_SPARE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgRowWe(cfgRowWe), .cfgSpareIdx(cfgSpareIdx), .cfgRowAddr(cfgRowAddr),
    .cfgRowValid(cfgRowValid), .cfgColWe(cfgColWe), .cfgColFuse(cfgColFuse),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .strobe(strobe), .colShift(colShift), .normWl(normWl), .spareWl(spareWl)
  );

  rmem_dpath #(.ROWS(ROWS), .NUM_SPARE(NUM_SPARE), .DATA_W(DATA_W),
               .BAD_ROW_MASK(BAD_ROW_MASK), .BAD_COL(BAD_COL)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colShift(colShift),
    .spareWl(spareWl), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData)
  );

endmodule

// File: rtl/rmem_chk.sv
module rmem_chk #(
  parameter int ROWS = 16,
  parameter int NUM_SPARE = 2,
  parameter int DATA_W = 8,
  localparam int ROW_AW = $clog2(ROWS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 memEn,
  input logic                 memWe,
  input logic [ROW_AW-1:0]    memAddr,
  input logic [DATA_W-1:0]    memRData,
  input logic [ROWS-1:0]      normWl,
  input logic [NUM_SPARE-1:0] spareWl
);

  // R3
  spare_blocks_norm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|spareWl) |-> (normWl == '0));

  // R5
  single_spare_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spareWl));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memEn |-> ((normWl == '0) && (spareWl == '0)));

  // R4
  norm_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && (spareWl == '0)) |-> (($countones(normWl) == 1) && normWl[memAddr]));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWe) |=> $stable(memRData));

endmodule

bind redundant_mem rmem_chk #(.ROWS(ROWS), .NUM_SPARE(NUM_SPARE), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
  .memRData(memRData), .normWl(normWl), .spareWl(spareWl)
);

// File: tb/sim_redundant_mem.sv
module sim_redundant_mem;

  localparam int ROWS = 16;
  localparam int NSP = 2;
  localparam int DW = 8;
  localparam int BADR0 = 3;
  localparam int BADR1 = 10;
  localparam int BADC = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgRowWe = 1'b0;
  logic [0:0]    cfgSpareIdx = '0;
  logic [3:0]    cfgRowAddr = '0;
  logic          cfgRowValid = 1'b0;
  logic          cfgColWe = 1'b0;
  logic [DW-1:0] cfgColFuse = '0;
  logic          memEn = 1'b0;
  logic          memWe = 1'b0;
  logic [3:0]    memAddr = '0;
  logic [DW-1:0] memWData = '0;
  logic [DW-1:0] memRData;
  logic [ROWS-1:0] normWl;
  logic [NSP-1:0]  spareWl;

  int nTests = 0;
  int nFail = 0;
  logic [DW-1:0] model [ROWS];
  logic [DW-1:0] rd;

  always #4 clk = ~clk;

  redundant_mem #(.ROWS(ROWS), .NUM_SPARE(NSP), .DATA_W(DW),
    .BAD_ROW_MASK(16'h0400 | 16'h0008), .BAD_COL(BADC)) u0 (
    .clk(clk), .rstN(rstN), .cfgRowWe(cfgRowWe), .cfgSpareIdx(cfgSpareIdx),
    .cfgRowAddr(cfgRowAddr), .cfgRowValid(cfgRowValid), .cfgColWe(cfgColWe),
    .cfgColFuse(cfgColFuse), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .normWl(normWl), .spareWl(spareWl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] expNorm(input logic [3:0] a);
    return ROWS'(1) << a;
  endfunction

  task automatic setSpare(input int k, input logic [3:0] a, input logic v);
    @(negedge clk);
    cfgRowWe = 1'b1; cfgSpareIdx = 1'(k); cfgRowAddr = a; cfgRowValid = v;
    @(negedge clk);
    cfgRowWe = 1'b0;
  endtask

  task automatic setFuse(input logic [DW-1:0] f);
    @(negedge clk);
    cfgColWe = 1'b1; cfgColFuse = f;
    @(negedge clk);
    cfgColWe = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    memEn = 1'b1; memWe = 1'b1; memAddr = a; memWData = d;
    @(negedge clk);
    memEn = 1'b0; memWe = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    memEn = 1'b1; memWe = 1'b0; memAddr = a;
    @(negedge clk);
    d = memRData;
    memEn = 1'b0;
  endtask

  task automatic peekWl(input logic [3:0] a);
    @(negedge clk);
    memEn = 1'b1; memWe = 1'b0; memAddr = a;
    #1;
  endtask

  initial begin
    #1600000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", memRData, 0);
    check("R4 idle norm", normWl, 0);
    check("R4 idle spare", spareWl, 0);
    peekWl(4'd3);
    check("R1 norm decode", normWl, expNorm(4'd3));
    check("R2 no spare after reset", spareWl, 0);
    memEn = 1'b0;

    // R6 unrepaired column 5 reads stuck one; identity mapping
    doWrite(4'd2, 8'h00); doRead(4'd2, rd);
    check("R6 identity uses col5", rd, 8'h20);
    setFuse(8'h80);
    doWrite(4'd2, 8'h00); doRead(4'd2, rd);
    check("R6 shift top only", rd, 8'h20);
    setFuse(8'hFF);
    doWrite(4'd2, 8'h00); doRead(4'd2, rd);
    check("R6 full shift hits col5 with bit4", rd, 8'h10);
    setFuse(8'hE0);
    doWrite(4'd2, 8'h00); doRead(4'd2, rd);
    check("R6 bypass col5", rd, 8'h00);
    doWrite(4'd2, 8'hFF); doRead(4'd2, rd);
    check("R6 bypass col5 ones", rd, 8'hFF);

    // R2 invalid spare never matches
    setSpare(0, 4'(BADR0), 1'b0);
    peekWl(4'(BADR0));
    check("R2 invalid spare", spareWl, 0);
    memEn = 1'b0;

    // Repair both stuck rows
    setSpare(0, 4'(BADR0), 1'b1);
    setSpare(1, 4'(BADR1), 1'b1);
    peekWl(4'(BADR1));
    check("R2 spare1 fires", spareWl, 2'b10);
    check("R3 normal held off", normWl, 0);
    memEn = 1'b0;

    // R8 fill and read back every address
    for (int a = 0; a < ROWS; a++) begin
      model[a] = 8'($urandom);
      doWrite(4'(a), model[a]);
    end
    for (int a = 0; a < ROWS; a++) begin
      doRead(4'(a), rd);
      check("R8 repaired readback", rd, model[a]);
    end

    // R7 random mix against the model
    for (int n = 0; n < 300; n++) begin
      logic [3:0] a;
      a = 4'($urandom);
      if ($urandom % 2 == 0) begin
        model[a] = 8'($urandom);
        doWrite(a, model[a]);
      end else begin
        doRead(a, rd);
        check("R7 random read", rd, model[a]);
      end
    end
    // R7 hold without read
    doRead(4'd7, rd);
    doWrite(4'd7, ~model[7]);
    check("R7 hold after write", memRData, model[7]);
    model[7] = ~model[7];

    // R5 two spares on the same address
    setSpare(1, 4'(BADR0), 1'b1);
    peekWl(4'(BADR0));
    check("R5 lowest spare wins", spareWl, 2'b01);
    memEn = 1'b0;
    doRead(4'(BADR0), rd);
    check("R5 data from spare0", rd, model[BADR0]);
    setSpare(0, 4'(BADR0), 1'b0);
    peekWl(4'(BADR0));
    check("R2 spare1 after spare0 cleared", spareWl, 2'b10);
    check("R3 normal held off again", normWl, 0);
    memEn = 1'b0;

    // R9 shadowed normal row keeps its contents
    doWrite(4'd2, 8'hA5);
    setSpare(0, 4'd2, 1'b1);
    doWrite(4'd2, 8'h3C);
    doRead(4'd2, rd);
    check("R9 spare data", rd, 8'h3C);
    setSpare(0, 4'd2, 1'b0);
    doRead(4'd2, rd);
    check("R9 normal untouched", rd, 8'hA5);

    // R4 random decode
    for (int n = 0; n < 20; n++) begin
      logic [3:0] a;
      a = 4'($urandom);
      if (a == 4'(BADR0)) a = 4'd0;
      peekWl(a);
      check("R4 decode", normWl, expNorm(a));
    end
    memEn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule